// File: doc/BRIEF.md
# Serial Byte Memory Command Engine

This block is the command side of a serial byte-addressed memory. A host talks to it over a four-wire serial peripheral link (clock, select, data in, data out) in clock-polarity/phase modes 0 or 3. Each time select goes low the first byte is an opcode. Seven opcodes are understood. Two of them, memory read and memory write, take a three-byte address and then move an unbounded stream of data bytes. The address steps by one per byte and wraps at the top of the space. Two more move a single status byte, in or out. The remaining three are bare commands whose effect is reported when select rises.

The serial pins are oversampled by the system clock. The engine drives a plain synchronous byte port towards an external array: address, write data, a one-cycle write strobe, and read data that arrives one cycle after the address. It leaves policy to a neighbouring protection unit. That unit grants or denies each memory byte write and each status write, supplies the status byte for readback, and receives the one-cycle command events. The array port and the protection port are plain signals, with no valid/ready: the array must accept every strobe in the cycle it is raised, so there is no back-pressure.

Top module: `sbm_cmd_engine`

## Requirements
- R1: Input bits are taken on rising edges of `spi_sck` and output bits change after falling edges, most significant bit first, in both idle-low (mode 0) and idle-high (mode 3) clock conventions.
- R2: The opcode is the first byte after select falls: 06h enable-set, 04h enable-clear, 05h status read, 01h status write, 03h memory read, 02h memory write, B9h sleep.
- R3: Only the first byte of a selection is decoded as an opcode; bytes that follow a bare command are not decoded.
- R4: Any other opcode value causes no strobe, no event and no output drive until select rises.
- R5: Read and write opcodes take three address bytes sent high byte first; of these 24 bits only the lowest `ADDR_W` bits are kept and the upper bits are ignored.
- R6: During a memory write, each complete data byte raises `mem_we` for exactly one cycle with `mem_addr` and `mem_wdata` valid, only if `prot_mem_ok` is high in that cycle. A denied byte writes nothing.
- R7: The memory address advances by one after every data byte, read or write, whether or not the write was granted, and wraps from all ones to zero; bursts have no length limit.
- R8: In a memory read, `spi_mosi` is ignored after the address, and each following byte is fetched in time for its first bit to appear on the falling edge after the previous byte's last bit.
- R9: `spi_miso_oe` is high only during the data phase of a memory read or status read, and low after reset, while select is high, and in all other phases.
- R10: A status read returns `prot_status` as one byte, after which the output is released.
- R11: A status write takes one byte and raises `stat_we` for one cycle with that byte on `stat_wdata`, only if `prot_stat_ok` is high; later bytes in the same selection are ignored.
- R12: On each rising edge of select one event may pulse for one cycle: `ev_en_set` after 06h, `ev_en_clr` after 04h, 01h or 02h, `ev_sleep` after B9h; at most one event at a time.
- R13: Select high clears the bit count, phase and address, so a partly shifted byte is dropped and the next selection starts again with an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (high impedance when low) |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_addr` |
| prot_mem_ok | input | 1 | Protection grants a write at `mem_addr` |
| prot_stat_ok | input | 1 | Protection grants a status write |
| prot_status | input | 8 | Status byte returned by a status read |
| stat_we | output | 1 | One-cycle status write strobe |
| stat_wdata | output | 8 | Status byte written |
| ev_en_set | output | 1 | Enable-set event at deselect |
| ev_en_clr | output | 1 | Enable-clear event at deselect |
| ev_sleep | output | 1 | Sleep event at deselect |

## Verification
The bench builds the engine with `ADDR_W` = 8 and `SYNC_STAGES` = 2, so the whole address space is 256 bytes. At that size a single write burst covers every location and passes the wrap point. A single read burst of 300 bytes crosses the wrap again and compares every location against arithmetic patterns computed in the bench. Because the space is so small, address truncation, partial-byte drops at deselect and denied writes can all be read back through the serial port and checked against a complete shadow image.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADR,
    PH_MRD,
    PH_MWR,
    PH_SRD,
    PH_SWR,
    PH_IDLE
  } phase_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SETEN,
    OP_CLREN,
    OP_RDST,
    OP_WRST,
    OP_RDMEM,
    OP_WRMEM,
    OP_SLEEP
  } cmd_t;

  localparam logic [7:0] CODE_SETEN = 8'h06;
  localparam logic [7:0] CODE_CLREN = 8'h04;
  localparam logic [7:0] CODE_RDST  = 8'h05;
  localparam logic [7:0] CODE_WRST  = 8'h01;
  localparam logic [7:0] CODE_RDMEM = 8'h03;
  localparam logic [7:0] CODE_WRMEM = 8'h02;
  localparam logic [7:0] CODE_SLEEP = 8'hB9;

  function automatic cmd_t decode_op(input logic [7:0] b);
    case (b)
      CODE_SETEN: decode_op = OP_SETEN;
      CODE_CLREN: decode_op = OP_CLREN;
      CODE_RDST:  decode_op = OP_RDST;
      CODE_WRST:  decode_op = OP_WRST;
      CODE_RDMEM: decode_op = OP_RDMEM;
      CODE_WRMEM: decode_op = OP_WRMEM;
      CODE_SLEEP: decode_op = OP_SLEEP;
      default:    decode_op = OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sbm_pin_sampler.sv
module sbm_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_hi,
  output logic cs_rise,
  output logic mosi_s
);

  // bit 0: clock, bit 1: select, bit 2: data
  logic [2:0] pipe [SYNC_STAGES];
  logic       sck_last;
  logic       cs_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= 3'b010;
      sck_last <= 1'b0;
      cs_last  <= 1'b1;
    end else begin
      pipe[0] <= {mosi, cs_n, sck};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      sck_last <= pipe[SYNC_STAGES-1][0];
      cs_last  <= pipe[SYNC_STAGES-1][1];
    end
  end

  assign sck_rise = pipe[SYNC_STAGES-1][0] & ~sck_last;
  assign sck_fall = ~pipe[SYNC_STAGES-1][0] & sck_last;
  assign cs_hi    = pipe[SYNC_STAGES-1][1];
  assign cs_rise  = pipe[SYNC_STAGES-1][1] & ~cs_last;
  assign mosi_s   = pipe[SYNC_STAGES-1][2];

endmodule

// File: rtl/sbm_addr_ctr.sv
module sbm_addr_ctr #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);

  // Shifting all address bits through keeps only the last ADDR_W of them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr <= '0;
    else if (clear)    addr <= '0;
    else if (shift_en) addr <= {addr[ADDR_W-2:0], shift_bit};
    else if (inc)      addr <= addr + 1'b1;
  end

endmodule

// File: rtl/sbm_tx_shift.sv
module sbm_tx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic       shift,
  input  logic [7:0] din,
  output logic       bit_out
);

  logic [7:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx <= '0;
    else if (clear) tx <= '0;
    else if (load)  tx <= din;
    else if (shift) tx <= {tx[6:0], 1'b0};
  end

  assign bit_out = tx[7];

endmodule

// File: rtl/sbm_cmd_engine.sv
module sbm_cmd_engine
  import sbm_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata,
  input  logic              prot_mem_ok,
  input  logic              prot_stat_ok,
  input  logic [7:0]        prot_status,
  output logic              stat_we,
  output logic [7:0]        stat_wdata,
  output logic              ev_en_set,
  output logic              ev_en_clr,
  output logic              ev_sleep
);

  localparam int AB_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [AB_W-1:0] AB_LAST = AB_W'(ADDR_BYTES - 1);

  logic sck_rise, sck_fall, cs_hi, cs_rise, mosi_s;

  sbm_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_hi    (cs_hi),
    .cs_rise  (cs_rise),
    .mosi_s   (mosi_s)
  );

  phase_t          ph;
  cmd_t            cmd;
  logic [2:0]      bitc;
  logic [AB_W-1:0] abyte;
  logic [6:0]      rx;
  logic [7:0]      byte_in;
  logic            drive;
  logic            we_q;
  logic            st_q;
  logic            rise_act, fall_act;
  logic            out_phase;

  assign byte_in   = {rx, mosi_s};
  assign rise_act  = sck_rise & ~cs_hi;
  assign fall_act  = sck_fall & ~cs_hi;
  assign out_phase = (ph == PH_MRD) || (ph == PH_SRD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_OPC;
      cmd        <= OP_NONE;
      bitc       <= '0;
      abyte      <= '0;
      rx         <= '0;
      drive      <= 1'b0;
      we_q       <= 1'b0;
      st_q       <= 1'b0;
      mem_wdata  <= '0;
      stat_wdata <= '0;
      ev_en_set  <= 1'b0;
      ev_en_clr  <= 1'b0;
      ev_sleep   <= 1'b0;
    end else begin
      we_q      <= 1'b0;
      st_q      <= 1'b0;
      ev_en_set <= cs_rise && (cmd == OP_SETEN);
      ev_en_clr <= cs_rise && ((cmd == OP_CLREN) || (cmd == OP_WRST) || (cmd == OP_WRMEM));
      ev_sleep  <= cs_rise && (cmd == OP_SLEEP);
      if (cs_hi) begin
        ph    <= PH_OPC;
        cmd   <= OP_NONE;
        bitc  <= '0;
        abyte <= '0;
        drive <= 1'b0;
      end else if (sck_rise) begin
        bitc <= bitc + 1'b1;
        rx   <= byte_in[6:0];
        case (ph)
          PH_OPC: if (bitc == 3'd7) begin
            cmd <= decode_op(byte_in);
            case (decode_op(byte_in))
              OP_RDST:           ph <= PH_SRD;
              OP_WRST:           ph <= PH_SWR;
              OP_RDMEM, OP_WRMEM: ph <= PH_ADR;
              default:           ph <= PH_IDLE;
            endcase
          end
          PH_ADR: if (bitc == 3'd7) begin
            abyte <= abyte + 1'b1;
            if (abyte == AB_LAST) ph <= (cmd == OP_RDMEM) ? PH_MRD : PH_MWR;
          end
          PH_MWR: if (bitc == 3'd7) begin
            we_q      <= 1'b1;
            mem_wdata <= byte_in;
          end
          PH_SRD: if (bitc == 3'd7) ph <= PH_IDLE;
          PH_SWR: if (bitc == 3'd7) begin
            st_q       <= 1'b1;
            stat_wdata <= byte_in;
            ph         <= PH_IDLE;
          end
          default: ;
        endcase
      end else if (sck_fall && out_phase) begin
        drive <= 1'b1;
      end
    end
  end

  // Address: shifted in during the address phase, stepped after each data byte.
  logic addr_inc;
  assign addr_inc = we_q | (rise_act & (ph == PH_MRD) & (bitc == 3'd7));

  sbm_addr_ctr #(.ADDR_W(ADDR_W)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cs_hi),
    .shift_en  (rise_act & (ph == PH_ADR)),
    .shift_bit (mosi_s),
    .inc       (addr_inc),
    .addr      (mem_addr)
  );

  sbm_tx_shift i_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cs_hi),
    .load    (fall_act & out_phase & (bitc == 3'd0)),
    .shift   (fall_act & out_phase & (bitc != 3'd0)),
    .din     ((ph == PH_SRD) ? prot_status : mem_rdata),
    .bit_out (spi_miso)
  );

  assign spi_miso_oe = drive & out_phase;
  assign mem_we      = we_q & prot_mem_ok;
  assign stat_we     = st_q & prot_stat_ok;

endmodule

// File: rtl/sbm_cmd_engine_chk.sv
module sbm_cmd_engine_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              stat_we,
  input logic              ev_en_set,
  input logic              ev_en_clr,
  input logic              ev_sleep
);

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R6

  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R7

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, stat_we})); // R11

  AST_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_en_set, ev_en_clr, ev_sleep})); // R12

  AST_EV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_en_set | ev_en_clr | ev_sleep) |=> !(ev_en_set | ev_en_clr | ev_sleep)); // R12

  AST_OE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R9

endmodule

bind sbm_cmd_engine sbm_cmd_engine_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_sbm_cmd_engine.sv
module test_sbm_cmd_engine;

  localparam int AW   = 8;
  localparam int SIZE = 1 << AW;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, stat_wdata;
  logic mem_we, stat_we, ev_en_set, ev_en_clr, ev_sleep;
  logic prot_mem_ok = 1'b1, prot_stat_ok = 1'b1;
  logic [7:0] prot_status = 8'h00;

  always #5 clk = ~clk;

  sbm_cmd_engine #(.ADDR_W(AW), .ADDR_BYTES(3), .SYNC_STAGES(2)) i_sbm_cmd_engine (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .prot_mem_ok(prot_mem_ok), .prot_stat_ok(prot_stat_ok),
    .prot_status(prot_status), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .ev_en_set(ev_en_set), .ev_en_clr(ev_en_clr), .ev_sleep(ev_sleep)
  );

  // array model and strobe/event counters
  logic [7:0] mem [SIZE];
  logic [7:0] expm [SIZE];
  int n_we = 0, n_swe = 0, n_set = 0, n_clr = 0, n_slp = 0;
  logic [7:0] last_sw = 8'h00;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (mem_we) n_we++;
    if (stat_we) begin n_swe++; last_sw = stat_wdata; end
    if (ev_en_set) n_set++;
    if (ev_en_clr) n_clr++;
    if (ev_sleep) n_slp++;
  end

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [7:0] rq, roe;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel(input bit mode3);
    spi_sck = mode3;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel(input bit mode3);
    spi_sck = mode3;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] d, input int nb);
    rq = '0; roe = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_sck = 1'b0; spi_mosi = d[i];
      repeat (HALF) @(negedge clk);
      rq[i] = spi_miso; roe[i] = spi_miso_oe;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xb(input logic [7:0] d);
    xbits(d, 8);
  endtask

  task automatic addr3(input logic [7:0] a2, input logic [7:0] a1, input logic [7:0] a0);
    xb(a2); xb(a1); xb(a0);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) & 8'hFF);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int b_we, b_set, b_clr, b_swe;
    for (int i = 0; i < SIZE; i++) begin mem[i] = 8'h00; expm[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    check("R9 reset oe", spi_miso_oe, 0);
    check("R12 reset events", n_set + n_clr + n_slp, 0);

    // bare commands and their deselect events
    sel(0); xb(8'h06); desel(0);
    check("R2 R12 enable-set event", n_set, 1);
    sel(1); xb(8'h04); desel(1);
    check("R2 R12 enable-clear event", n_clr, 1);
    sel(0); xb(8'hB9); desel(0);
    check("R2 R12 sleep event", n_slp, 1);
    sel(0); xb(8'h03); desel(0);
    check("R12 read gives no event", n_set + n_clr + n_slp, 3);

    // full-space write burst from 10h, crossing the wrap
    sel(0); xb(8'h02); addr3(8'h00, 8'h00, 8'h10);
    for (int i = 0; i < SIZE; i++) begin
      xb(pat(i));
      expm[(16 + i) % SIZE] = pat(i);
    end
    desel(0);
    check("R6 one strobe per byte", n_we, SIZE);
    check("R12 write clears enable", n_clr, 2);
    for (int a = 0; a < SIZE; a++) check($sformatf("R6 R7 array[%0h]", a), mem[a], expm[a]);

    // read burst in mode 3 from F0h, 300 bytes, junk on data in
    b_we = n_we;
    sel(1); xb(8'h03); addr3(8'h00, 8'h00, 8'hF0);
    for (int i = 0; i < 300; i++) begin
      xb(8'h02 ^ 8'(i));
      check($sformatf("R8 R7 R1 read byte %0d", i), rq, expm[(240 + i) % SIZE]);
      check("R9 oe during read data", roe, 8'hFF);
    end
    desel(1);
    check("R8 read writes nothing", n_we, b_we);
    check("R9 oe after deselect", spi_miso_oe, 0);

    // upper address bits ignored
    sel(0); xb(8'h03); addr3(8'hFF, 8'hFF, 8'h05); xb(8'h00);
    check("R5 truncated address", rq, expm[5]);
    desel(0);

    // status read
    prot_status = 8'hA5;
    sel(0); xb(8'h05);
    check("R9 oe during opcode", roe, 0);
    xb(8'hFF);
    check("R10 status value", rq, 8'hA5);
    check("R10 R9 oe on status", roe, 8'hFF);
    xb(8'hFF);
    check("R10 released after one byte", roe, 0);
    desel(0);

    // status write, granted then denied
    sel(1); xb(8'h01); xb(8'h8C); xb(8'h33); desel(1);
    check("R11 one status strobe", n_swe, 1);
    check("R11 status data", last_sw, 8'h8C);
    check("R12 status write clears enable", n_clr, 3);
    prot_stat_ok = 1'b0;
    sel(0); xb(8'h01); xb(8'h44); desel(0);
    prot_stat_ok = 1'b1;
    check("R11 denied status write", n_swe, 1);

    // denied memory write still advances address
    b_we = n_we;
    prot_mem_ok = 1'b0;
    sel(0); xb(8'h02); addr3(8'h00, 8'h00, 8'h20);
    for (int i = 0; i < 4; i++) xb(8'hE0 + 8'(i));
    desel(0);
    prot_mem_ok = 1'b1;
    check("R6 denied writes strobe nothing", n_we, b_we);
    sel(1); xb(8'h03); addr3(8'h00, 8'h00, 8'h20);
    for (int i = 0; i < 4; i++) begin
      xb(8'h00);
      check("R6 denied bytes unchanged", rq, expm[32 + i]);
    end
    desel(1);

    // unknown opcode
    b_set = n_set; b_clr = n_clr; b_swe = n_swe;
    sel(0); xb(8'hAA);
    xb(8'h02); addr3(8'h00, 8'h00, 8'h40); xb(8'h77);
    check("R4 no drive after unknown opcode", roe, 0);
    desel(0);
    check("R4 unknown opcode no strobe", n_we + n_swe, b_we + b_swe);
    check("R4 unknown opcode no event", n_set + n_clr, b_set + b_clr);

    // one opcode per selection
    sel(1); xb(8'h06); xb(8'h04); xb(8'h02); addr3(8'h00, 8'h00, 8'h50); xb(8'h99); desel(1);
    check("R3 only first opcode events", n_set, b_set + 1);
    check("R3 later opcodes ignored", n_clr, b_clr);
    check("R3 no write after bare command", n_we, b_we);

    // partial byte dropped at deselect, next selection restarts
    sel(1); xb(8'h02); addr3(8'h00, 8'h00, 8'h60); xb(8'h5A); xbits(8'hF0, 4); desel(1);
    expm[8'h60] = 8'h5A;
    check("R13 partial byte dropped", n_we, b_we + 1);
    sel(0); xb(8'h03); addr3(8'h00, 8'h00, 8'h60);
    xb(8'h00); check("R13 full byte written", rq, expm[8'h60]);
    xb(8'h00); check("R13 next location untouched", rq, expm[8'h61]);
    desel(0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule